// File: doc/BRIEF.md
# Piecewise-Linear Fixed-Point Function Evaluator

This block computes a smooth monotone nonlinear function of an unsigned fixed-point word by splitting the input into a segment index and a position inside that segment. The index selects one entry of a coefficient table. The entry holds a coarse result, a slope and a signed offset. The coarse result becomes the upper half of the output unchanged. The lower half is a short product: the slope times the in-segment position minus the offset. No adder spans the full output width, so the critical path is one narrow subtract followed by one narrow multiply.

The datapath has two register stages. The first looks up the table and forms the clamped difference. The second forms the product and joins it to the coarse value. A single valid bit travels with each sample. The table comes out of reset with a built-in curve, and a write port can replace any entry at run time. Coefficients are assumed to be fitted elsewhere.

Top module: `pwl_eval`

## Requirements
- R1: The upper SEG_W bits of x_i pick a table entry. The upper SEG_W bits of y_o equal that entry's coarse value b.
- R2: With FRAC = S_W - (IN_W - SEG_W), the lower IN_W-SEG_W bits of y_o equal floor(k * (x_low * 2^FRAC - S) / 2^(K_W+FRAC)). Here x_low is the lower IN_W-SEG_W bits of x_i, k is unsigned and S is two's complement.
- R3: When x_low * 2^FRAC - S is negative, the lower part of y_o is zero.
- R4: When the R2 quotient reaches 2^(IN_W-SEG_W) or more, the lower part of y_o is all ones.
- R5: out_valid_o equals in_valid_i from exactly two clock cycles earlier. The y_o shown with it is the result for the x_i that was sampled with that in_valid_i.
- R6: While out_valid_o is low, y_o keeps its last value.
- R7: While rst_ni is low, out_valid_o is 0 and y_o is 0. After reset, every table entry holds its default value.
- R8: The default value of entry i is b = i, k = 2^K_W - 1 - floor(i/2) and S = -floor(i/8).
- R9: When load_en_i is high at a clock edge, entry load_addr_i is written. The data layout is b in the top SEG_W bits, k in the next K_W bits and S in the low S_W bits. A lookup sampled at the same edge still uses the old entry. Lookups sampled at later edges use the new entry.
- R10: A new input can be accepted on every cycle, and each one gives its own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| x_i | input | IN_W | Unsigned fixed-point argument |
| load_en_i | input | 1 | Coefficient write enable |
| load_addr_i | input | SEG_W | Entry to write |
| load_data_i | input | SEG_W+K_W+S_W | Packed {b, k, S} |
| out_valid_o | output | 1 | Result valid |
| y_o | output | IN_W | Result {b, low part} |

## Verification
A stale or corrupted table entry shows up two cycles after the first lookup that lands in its segment. It appears either as a wrong upper byte or as a wrong slope or intercept across that segment's low codes. For this reason the bench sweeps every input code over a randomly loaded table. Errors in the clamp and saturation logic only show up at the segment edges and at the extreme coefficient values, which the random table reaches often. A slip in the valid pipeline shows immediately as a result paired with the wrong sample. It also shows as an output that changes while out_valid_o is low.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  // default curve: concave, slope halves across the range
  function automatic int dflt_b(int i);
    return i;
  endfunction

  function automatic int dflt_k(int i, int k_w);
    return (1 << k_w) - 1 - (i >> 1);
  endfunction

  function automatic int dflt_s(int i);
    return -(i >> 3);
  endfunction
endpackage

// File: rtl/pwl_coef_table.sv
module pwl_coef_table #(
  parameter int SEG_W = 8,
  parameter int K_W   = 8,
  parameter int S_W   = 11,
  localparam int N    = 1 << SEG_W,
  localparam int E_W  = SEG_W + K_W + S_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] waddr_i,
  input  logic [E_W-1:0]   wdata_i,
  input  logic [SEG_W-1:0] raddr_i,
  output logic [SEG_W-1:0] b_o,
  output logic [K_W-1:0]   k_o,
  output logic [S_W-1:0]   s_o
);
  logic [E_W-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++)
        mem_q[i] <= {SEG_W'(pwl_pkg::dflt_b(i)),
                     K_W'(pwl_pkg::dflt_k(i, K_W)),
                     S_W'(pwl_pkg::dflt_s(i))};
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    {b_o, k_o, s_o} = mem_q[raddr_i];
  end
endmodule

// File: rtl/pwl_offset_sub.sv
module pwl_offset_sub #(
  parameter int SEG_W  = 8,
  parameter int FRAC_W = 8,
  parameter int K_W    = 8,
  parameter int S_W    = 11,
  localparam int SH_W  = S_W - FRAC_W,
  localparam int D_W   = S_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FRAC_W-1:0] xl_i,
  input  logic [SEG_W-1:0]  b_i,
  input  logic [K_W-1:0]    k_i,
  input  logic [S_W-1:0]    s_i,
  output logic              valid_o,
  output logic [SEG_W-1:0]  b_o,
  output logic [K_W-1:0]    k_o,
  output logic [S_W:0]      d_o
);
  logic signed [D_W-1:0] x_ext, s_ext, diff;
  logic        [S_W:0]   d_sat;

  always_comb begin
    x_ext = $signed({2'b00, xl_i, {SH_W{1'b0}}});
    s_ext = $signed({{2{s_i[S_W-1]}}, s_i});
    diff  = x_ext - s_ext;
    d_sat = diff[D_W-1] ? '0 : diff[S_W:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      b_o     <= '0;
      k_o     <= '0;
      d_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        b_o <= b_i;
        k_o <= k_i;
        d_o <= d_sat;
      end
    end
  end
endmodule

// File: rtl/pwl_mul_cat.sv
module pwl_mul_cat #(
  parameter int SEG_W  = 8,
  parameter int FRAC_W = 8,
  parameter int K_W    = 8,
  parameter int S_W    = 11,
  localparam int SH_W  = S_W - FRAC_W,
  localparam int P_W   = K_W + S_W + 1,
  localparam int SHIFT = K_W + SH_W,
  localparam int OUT_W = SEG_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic [K_W-1:0]   k_i,
  input  logic [S_W:0]     d_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] y_o
);
  logic [P_W-1:0]    prod;
  logic [FRAC_W:0]   hi;
  logic [FRAC_W-1:0] low;

  always_comb begin
    prod = P_W'(k_i) * P_W'(d_i);
    hi   = (FRAC_W+1)'(prod >> SHIFT);
    low  = hi[FRAC_W] ? '1 : hi[FRAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= {b_i, low};
    end
  end
endmodule

// File: rtl/pwl_eval.sv
module pwl_eval #(
  parameter int IN_W  = 16,
  parameter int SEG_W = 8,
  parameter int K_W   = 8,
  parameter int S_W   = 11,
  localparam int FRAC_W = IN_W - SEG_W,
  localparam int E_W    = SEG_W + K_W + S_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  x_i,
  input  logic             load_en_i,
  input  logic [SEG_W-1:0] load_addr_i,
  input  logic [E_W-1:0]   load_data_i,
  output logic             out_valid_o,
  output logic [IN_W-1:0]  y_o
);
  logic [SEG_W-1:0] tb_b, s1_b;
  logic [K_W-1:0]   tb_k, s1_k;
  logic [S_W-1:0]   tb_s;
  logic [S_W:0]     s1_d;
  logic             s1_valid;

  pwl_coef_table #(.SEG_W(SEG_W), .K_W(K_W), .S_W(S_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_en_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (x_i[IN_W-1 -: SEG_W]),
    .b_o     (tb_b),
    .k_o     (tb_k),
    .s_o     (tb_s)
  );

  pwl_offset_sub #(.SEG_W(SEG_W), .FRAC_W(FRAC_W), .K_W(K_W), .S_W(S_W)) u_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .xl_i    (x_i[FRAC_W-1:0]),
    .b_i     (tb_b),
    .k_i     (tb_k),
    .s_i     (tb_s),
    .valid_o (s1_valid),
    .b_o     (s1_b),
    .k_o     (s1_k),
    .d_o     (s1_d)
  );

  pwl_mul_cat #(.SEG_W(SEG_W), .FRAC_W(FRAC_W), .K_W(K_W), .S_W(S_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .b_i     (s1_b),
    .k_i     (s1_k),
    .d_i     (s1_d),
    .valid_o (out_valid_o),
    .y_o     (y_o)
  );
endmodule

// File: rtl/pwl_eval_chk.sv
module pwl_eval_chk #(
  parameter int IN_W  = 16,
  parameter int SEG_W = 8,
  parameter int S_W   = 11,
  localparam int FRAC_W = IN_W - SEG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [IN_W-1:0]  y_o,
  input logic [SEG_W-1:0] s1_b,
  input logic [S_W:0]     s1_d
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (!out_valid_o && y_o == '0); // R7
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !out_valid_o) |-> $stable(y_o)); // R6

  AST_UPPER_COARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && out_valid_o && $past(s1_b) == $past(s1_b)) |->
      (y_o[IN_W-1 -: SEG_W] == $past(s1_b))); // R1

  AST_NEG_DIFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && out_valid_o && $past(s1_d) == '0) |->
      (y_o[FRAC_W-1:0] == '0)); // R3
endmodule

bind pwl_eval pwl_eval_chk #(.IN_W(IN_W), .SEG_W(SEG_W), .S_W(S_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .y_o         (y_o),
  .s1_b        (s1_b),
  .s1_d        (s1_d)
);

// File: tb/pwl_eval_tb.sv
module pwl_eval_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [15:0] x_i = '0;
  logic        load_en_i = 1'b0;
  logic [7:0]  load_addr_i = '0;
  logic [26:0] load_data_i = '0;
  logic        out_valid_o;
  logic [15:0] y_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  int m_b[256];
  int m_k[256];
  int m_s[256];
  bit dflt_tab;

  bit    p_v[2];
  int    p_y[2];
  string p_t[2];
  int    last_y;

  always #5 clk_i = ~clk_i;

  pwl_eval u_dut (
    .clk_i, .rst_ni, .in_valid_i, .x_i, .load_en_i,
    .load_addr_i, .load_data_i, .out_valid_o, .y_o
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R8 default coefficients
  task automatic load_defaults();
    for (int i = 0; i < 256; i++) begin
      m_b[i] = i;
      m_k[i] = 255 - (i >> 1);
      m_s[i] = -(i >> 3);
    end
    dflt_tab = 1;
  endtask

  function automatic int model(int x, output string kind);
    int seg, xl, d, lo;
    seg = (x >> 8) & 255;
    xl  = x & 255;
    d   = xl * 8 - m_s[seg];
    kind = "R2";
    if (d < 0) begin d = 0; kind = "R3"; end
    lo = (m_k[seg] * d) >> 11;
    if (lo > 255) begin lo = 255; kind = "R4"; end
    return (m_b[seg] << 8) | lo;
  endfunction

  task automatic step(bit v, int x, bit ld, int la, int lb, int lk, int ls, string extra);
    string kind;
    int    e;
    @(negedge clk_i);
    chk(out_valid_o == p_v[1], {"R5 valid ", p_t[1]}, out_valid_o, p_v[1]);
    if (p_v[1]) begin
      chk(y_o[15:8] == p_y[1][15:8], {"R1 ", p_t[1]}, y_o[15:8], p_y[1][15:8]);
      chk(y_o[7:0] == p_y[1][7:0], p_t[1], y_o[7:0], p_y[1][7:0]);
      last_y = p_y[1];
    end else begin
      chk(y_o == 16'(last_y), "R6 hold", y_o, last_y);
    end
    e = model(x, kind);
    p_v[1] = p_v[0]; p_y[1] = p_y[0]; p_t[1] = p_t[0];
    p_v[0] = v;
    p_y[0] = e;
    p_t[0] = {kind, dflt_tab ? " R8" : "", extra};
    in_valid_i  = v;
    x_i         = 16'(x);
    load_en_i   = ld;
    load_addr_i = 8'(la);
    load_data_i = {8'(lb), 8'(lk), 11'(ls)};
    if (ld) begin
      m_b[la] = lb; m_k[la] = lk; m_s[la] = ls;
      dflt_tab = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    in_valid_i = 0; load_en_i = 0;
    rst_ni = 0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R7 valid in reset", out_valid_o, 0);
    chk(y_o == 16'h0, "R7 data in reset", y_o, 0);
    rst_ni = 1;
    load_defaults();
    p_v[0] = 0; p_v[1] = 0; p_y[0] = 0; p_y[1] = 0;
    p_t[0] = ""; p_t[1] = "";
    last_y = 0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    #1 rst_ni = 0;
    do_reset();

    // directed corners on default table, back to back
    step(1, 16'h0000, 0, 0, 0, 0, 0, " R10");
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, " R10");
    step(1, 16'h80FF, 0, 0, 0, 0, 0, " R10");
    step(1, 16'h1234, 0, 0, 0, 0, 0, " R10");
    step(1, 16'hF800, 0, 0, 0, 0, 0, " R10");
    step(0, 0, 0, 0, 0, 0, 0, "");

    // random stream with gaps on default table
    for (int i = 0; i < 20000; i++)
      step(($urandom % 8) != 0, $urandom & 16'hFFFF, 0, 0, 0, 0, 0, "");

    // random coefficients over the full field ranges
    for (int a = 0; a < 256; a++)
      step(0, 0, 1, a, $urandom & 255, $urandom & 255,
           int'($urandom % 2048) - 1024, " R9");

    // same-edge write and lookup: old entry, then new entry
    step(1, 16'h3377, 1, 16'h33, 8'hA5, 8'hFF, -1024, " R9 old");
    step(1, 16'h3377, 0, 0, 0, 0, 0, " R9 new");
    step(1, 16'h3300, 0, 0, 0, 0, 0, " R9 new");

    // full sweep of every code over the loaded table
    for (int x = 0; x < 65536; x++) begin
      if (($urandom % 10) == 0) step(0, 0, 0, 0, 0, 0, 0, "");
      step(1, x, 0, 0, 0, 0, 0, "");
    end
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, "");

    // reset restores defaults
    do_reset();
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, " R7");
    step(1, 16'h3377, 0, 0, 0, 0, 0, " R7");
    step(1, 16'h0001, 0, 0, 0, 0, 0, " R7");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, "");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule